// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

This controller gathers a bank of level-sensitive request lines and presents them to a processor core as a single request wire plus a vector code. Ordinary lines are held in a raw pending register, gated by a software-owned enable mask, and the surviving set is encoded. A lone active source yields a source-specific code. Two or more active sources yield one shared code, and software then scans the masked pending register to decide which to serve first.

The highest-numbered lines go down a separate path that ignores the mask. Their levels appear in an NMI status register and drive a dedicated non-maskable request output. A plain 32-bit register port lets software write the mask and read back the mask, the raw and masked pending sets, the NMI status and a reserved word. The register index is the byte address shifted right by two.

Top module: `vec_intc`

## Requirements
- R1: While `rst` is high at a clock edge, the mask, raw pending and NMI status registers clear to zero, `cpu_vector` becomes 0 and `cpu_irq` and `cpu_nmi` go low.
- R2: A write with byte address 0 loads the mask register, which reads back at byte address 0. A write to any other address leaves every register unchanged.
- R3: For each ordinary line n, where 1 <= n <= NMI_FIRST-1 (29 by default), bit n-1 of the raw pending register, read at byte address 4, follows the level of line n. Raw bits at positions NMI_FIRST-1 and above read zero.
- R4: The masked pending register, read at byte address 8, equals the raw pending register ANDed with the mask.
- R5: When exactly masked bit i is set, `cpu_vector` is 0x31 + i and `cpu_irq` is high. For example, line 1 gives 0x31 and line 29 gives 0x4D.
- R6: When two or more masked bits are set, `cpu_vector` is 0x30 and `cpu_irq` is high.
- R7: When no masked bit is set, `cpu_vector` is 0 and `cpu_irq` is low, even if raw bits are pending.
- R8: Lines NMI_FIRST and above (30 and 31 by default) set NMI status bit n to the level of line n, read at byte address 12. `cpu_nmi` is high while any of these bits is set, whatever the mask holds. These lines never touch the raw pending register or the vector.
- R9: Line 0 has no effect. The reserved word at byte address 16 and every unmapped address read zero.
- R10: The outputs and the registers change on the clock edge after an input or mask change, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive request lines |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; `reg_rdata` is zero when low |
| reg_rdata | output | 32 | Read data from the current register state |
| cpu_irq | output | 1 | Maskable request to the core |
| cpu_vector | output | VEC_W | Encoded vector of the pending source |
| cpu_nmi | output | 1 | Non-maskable request to the core |

## Verification
The hardest case to reach from the ports is the mask taking effect on the same edge as a line change. The vector must then reflect the new mask against the new levels, and must not show a stale mix of old and new. The stimulus builds a two-source pending set first. It then narrows the mask to one of the two sources and later clears it, and each step must move the vector from the shared code to a single-source code and then to zero while the raw pending register stays fixed. NMI lines are raised while the mask is zero, which shows that the non-maskable path ignores the mask.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
   localparam int REG_W      = 32;
   localparam int IDX_MASK   = 0;
   localparam int IDX_RAW    = 1;
   localparam int IDX_MASKED = 2;
   localparam int IDX_NMI    = 3;
   localparam int IDX_RSVD   = 4;
   localparam int IDX_COUNT  = 5;
endpackage

// File: rtl/vec_intc_capture.sv
module vec_intc_capture
   import vec_intc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int NMI_FIRST = 30
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] lines,
   output logic [REG_W-1:0]     raw_d,
   output logic [REG_W-1:0]     raw_q,
   output logic [REG_W-1:0]     nmi_d,
   output logic [REG_W-1:0]     nmi_q
);
   localparam int NORM_W = NMI_FIRST - 1;

   logic unused_line0;
   assign unused_line0 = lines[0];

   // ordinary lines map one position down
   for (genvar n = 1; n < NMI_FIRST; n++) begin : g_norm
      assign raw_d[n-1] = lines[n];
   end
   assign raw_d[REG_W-1:NORM_W] = '0;

   // non-maskable lines keep their own position
   if (NMI_FIRST < NUM_LINES) begin : g_nmi
      always_comb begin
         nmi_d = '0;
         for (int n = NMI_FIRST; n < NUM_LINES; n++) nmi_d[n] = lines[n];
      end
   end else begin : g_no_nmi
      assign nmi_d = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         raw_q <= '0;
         nmi_q <= '0;
      end else begin
         raw_q <= raw_d;
         nmi_q <= nmi_d;
      end
   end
endmodule

// File: rtl/vec_intc_enc.sv
module vec_intc_enc #(
   parameter int              SRC_W  = 29,
   parameter int              VEC_W  = 8,
   parameter logic [VEC_W-1:0] BASE   = 8'h31,
   parameter logic [VEC_W-1:0] SHARED = 8'h30
) (
   input  logic [SRC_W-1:0] act,
   output logic [VEC_W-1:0] vec
);
   logic [VEC_W-1:0] low_idx;
   logic             any_act;
   logic             multi;

   always_comb begin
      low_idx = '0;
      for (int i = SRC_W - 1; i >= 0; i--) begin
         if (act[i]) low_idx = VEC_W'(i);
      end
      any_act = |act;
      multi   = |(act & (act - 1'b1));
      if (!any_act)   vec = '0;
      else if (multi) vec = SHARED;
      else            vec = BASE + low_idx;
   end
endmodule

// File: rtl/vec_intc_rdmux.sv
module vec_intc_rdmux
   import vec_intc_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             rd_en,
   input  logic [REG_W-1:0] mask,
   input  logic [REG_W-1:0] raw,
   input  logic [REG_W-1:0] nmi,
   output logic [REG_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (idx)
            IDX_W'(IDX_MASK):   rdata = mask;
            IDX_W'(IDX_RAW):    rdata = raw;
            IDX_W'(IDX_MASKED): rdata = raw & mask;
            IDX_W'(IDX_NMI):    rdata = nmi;
            default:            rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
   import vec_intc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int NMI_FIRST = 30,
   parameter int ADDR_W    = 5,
   parameter int VEC_W     = 8,
   parameter logic [VEC_W-1:0] VEC_BASE   = 8'h31,
   parameter logic [VEC_W-1:0] VEC_SHARED = 8'h30
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [31:0]          reg_wdata,
   input  logic                 reg_rd,
   output logic [31:0]          reg_rdata,
   output logic                 cpu_irq,
   output logic [VEC_W-1:0]     cpu_vector,
   output logic                 cpu_nmi
);
   localparam int NORM_W = NMI_FIRST - 1;
   localparam int IDX_W  = ADDR_W - 2;

   if (NUM_LINES > REG_W || NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must lie in 2..32");
   end
   if (NMI_FIRST < 2 || NMI_FIRST > NUM_LINES) begin : g_bad_nmi
      $error("NMI_FIRST must lie in 2..NUM_LINES");
   end
   if ((1 << IDX_W) < IDX_COUNT) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (int'(VEC_BASE) + NORM_W - 1 >= (1 << VEC_W)) begin : g_bad_vec
      $error("VEC_W too narrow for the vector range");
   end

   logic [REG_W-1:0] raw_d, raw_q, nmi_d, nmi_q;
   logic [REG_W-1:0] mask_q, mask_d;
   logic [VEC_W-1:0] vec_d;
   logic [IDX_W-1:0] idx;
   logic [1:0]       unused_lsb;

   assign idx        = reg_addr[ADDR_W-1:2];
   assign unused_lsb = reg_addr[1:0];

   vec_intc_capture #(.NUM_LINES(NUM_LINES), .NMI_FIRST(NMI_FIRST)) u_cap (
      .clk(clk), .rst(rst), .lines(irq_lines),
      .raw_d(raw_d), .raw_q(raw_q), .nmi_d(nmi_d), .nmi_q(nmi_q)
   );

   assign mask_d = (reg_wr && idx == IDX_W'(IDX_MASK)) ? reg_wdata : mask_q;

   vec_intc_enc #(.SRC_W(NORM_W), .VEC_W(VEC_W), .BASE(VEC_BASE), .SHARED(VEC_SHARED)) u_enc (
      .act(raw_d[NORM_W-1:0] & mask_d[NORM_W-1:0]),
      .vec(vec_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q     <= '0;
         cpu_vector <= '0;
         cpu_irq    <= 1'b0;
         cpu_nmi    <= 1'b0;
      end else begin
         mask_q     <= mask_d;
         cpu_vector <= vec_d;
         cpu_irq    <= |(raw_d & mask_d);
         cpu_nmi    <= |nmi_d;
      end
   end

   vec_intc_rdmux #(.IDX_W(IDX_W)) u_rd (
      .idx(idx), .rd_en(reg_rd), .mask(mask_q), .raw(raw_q), .nmi(nmi_q),
      .rdata(reg_rdata)
   );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
   parameter int NUM_LINES = 32,
   parameter int NMI_FIRST = 30,
   parameter int ADDR_W    = 5,
   parameter int VEC_W     = 8,
   parameter logic [VEC_W-1:0] VEC_SHARED = 8'h30
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_wr,
   input logic                 cpu_irq,
   input logic [VEC_W-1:0]     cpu_vector,
   input logic                 cpu_nmi,
   input logic [31:0]          mask_q,
   input logic [31:0]          raw_q
);
   logic any_nmi_line;
   assign any_nmi_line = |(irq_lines >> NMI_FIRST);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cpu_vector == '0 && !cpu_irq && !cpu_nmi));

   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr[ADDR_W-1:2] != '0) |=> $stable(mask_q));

   // R6
   shared_vec_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(raw_q & mask_q) > 1) |-> (cpu_vector == VEC_SHARED && cpu_irq));

   // R5
   single_vec_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(raw_q & mask_q) == 1) |-> (cpu_vector > VEC_SHARED && cpu_irq));

   // R7
   idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
      ((raw_q & mask_q) == '0) |-> (cpu_vector == '0 && !cpu_irq));

   // R8
   nmi_rise_chk: assert property (@(posedge clk) disable iff (rst)
      any_nmi_line |=> cpu_nmi);

   // R8
   nmi_fall_chk: assert property (@(posedge clk) disable iff (rst)
      !any_nmi_line |=> !cpu_nmi);
endmodule

bind vec_intc vec_intc_chk #(
   .NUM_LINES(NUM_LINES), .NMI_FIRST(NMI_FIRST), .ADDR_W(ADDR_W),
   .VEC_W(VEC_W), .VEC_SHARED(VEC_SHARED)
) u_chk (
   .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector),
   .cpu_nmi(cpu_nmi), .mask_q(mask_q), .raw_q(raw_q)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] irq_lines = '0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        cpu_irq;
   logic [7:0]  cpu_vector;
   logic        cpu_nmi;

   always #2 clk = ~clk;

   vec_intc u_vec_intc (
      .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector),
      .cpu_nmi(cpu_nmi)
   );

   typedef struct {
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   logic  chk_en = 1'b0;
   int    tests = 0;
   int    fails = 0;

   // monitor: compares one expected item per flagged cycle
   always @(negedge clk) begin
      if (chk_en) begin
         item_t it;
         logic [31:0] act;
         it  = sb.pop_front();
         act = it.is_rd ? reg_rdata : {22'b0, cpu_nmi, cpu_irq, cpu_vector};
         tests++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic idle_all();
      reg_wr = 1'b0; reg_rd = 1'b0; chk_en = 1'b0;
   endtask

   task automatic set_lines(input logic [31:0] v);
      @(posedge clk); #1;
      idle_all();
      irq_lines = v;
   endtask

   task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      idle_all();
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      idle_all();
      reg_rd = 1'b1; reg_addr = a;
      it.is_rd = 1'b1; it.exp = e; it.tag = tag;
      sb.push_back(it);
      chk_en = 1'b1;
   endtask

   // output word: {nmi, irq, vector[7:0]}
   task automatic exp_out(input logic [31:0] e, input string tag, input bit now);
      item_t it;
      if (!now) begin
         @(posedge clk); #1;
         idle_all();
      end
      it.is_rd = 1'b0; it.exp = e; it.tag = tag;
      sb.push_back(it);
      chk_en = 1'b1;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      irq_lines = 32'h0000_0021;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      irq_lines = '0;
      exp_out(32'h0, "R1 outputs after reset", 1);
      exp_rd(5'd0,  32'h0, "R1 mask after reset");
      exp_rd(5'd12, 32'h0, "R1 nmi after reset");

      write_reg(5'd0, 32'hFFFF_FFFF);
      exp_rd(5'd0, 32'hFFFF_FFFF, "R2 mask readback");

      set_lines(32'h0000_0020);
      exp_out(32'h0, "R10 no change before edge", 1);
      exp_out(32'h135, "R5 single source line 5", 0);
      exp_rd(5'd4, 32'h0000_0010, "R3 raw pending line 5");

      set_lines(32'h0000_0220);
      exp_out(32'h130, "R6 two sources shared vector", 0);
      exp_rd(5'd4, 32'h0000_0110, "R3 raw pending two lines");

      write_reg(5'd0, 32'h0000_0010);
      exp_out(32'h135, "R4 narrowed mask vector", 0);
      exp_rd(5'd8, 32'h0000_0010, "R4 masked pending");

      write_reg(5'd0, 32'h0);
      exp_out(32'h0, "R7 mask hides pending", 0);
      exp_rd(5'd4, 32'h0000_0110, "R7 raw still pending");

      write_reg(5'd4, 32'hFFFF_FFFF);
      exp_rd(5'd0, 32'h0, "R2 write to raw ignored (mask)");
      exp_rd(5'd4, 32'h0000_0110, "R2 write to raw ignored (raw)");

      set_lines(32'h4000_0220);
      exp_out(32'h200, "R8 nmi despite zero mask", 0);
      exp_rd(5'd12, 32'h4000_0000, "R8 nmi status line 30");
      exp_rd(5'd4, 32'h0000_0110, "R8 raw untouched by nmi");

      write_reg(5'd0, 32'hFFFF_FFFF);
      set_lines(32'h0000_0001);
      exp_out(32'h0, "R9 line 0 no effect", 0);
      exp_rd(5'd4, 32'h0, "R9 raw with line 0");
      exp_rd(5'd16, 32'h0, "R9 reserved word");
      exp_rd(5'd20, 32'h0, "R9 unmapped address");

      set_lines(32'h2000_0000);
      exp_out(32'h14D, "R5 highest ordinary line", 0);
      set_lines(32'h0000_0002);
      exp_out(32'h131, "R5 lowest ordinary line", 0);
      set_lines(32'h8000_0000);
      exp_out(32'h200, "R8 line 31 nmi", 0);
      exp_rd(5'd12, 32'h8000_0000, "R8 nmi status line 31");

      @(posedge clk); #1;
      idle_all();
      @(posedge clk); #1;
      if (sb.size() != 0) begin
         tests++; fails++;
         $display("FAIL scoreboard left %0d items, expected 0", sb.size());
      end
      finish_run();
   end
endmodule